// File: doc/BRIEF.md
# Speed-Mode PHY Configuration Sequencer

This block turns a requested bus speed mode into the function-control settings of a card-interface PHY and applies them in a safe order. A request is the mode code together with a flag saying that the card is SDIO, a board flag that asks for slow (bypass) operation, a flag saying that the card clock runs above 52 MHz, the bus width and a one-cycle apply strobe.

When a request is accepted, the sequencer first decides whether slow bypass applies and updates the SDIO-mode bit. It then takes one of two paths. On the fast path it gates the card clock off, writes the lane DDR, command DDR and async settings, and re-enables the clock. It then either loads a fixed logic-timing word and sets data-strobe enable (HS400), or clears data-strobe enable. Legacy mode and slow bypass skip all of that. Both paths end by pulsing the start of the PHY initialization sequencer and wait for its completion.

The states are IDLE, DECIDE, CLK_OFF, FC_WRITE, CLK_ON, KICK and WAIT. The transitions are:
- IDLE to DECIDE on an accepted apply.
- DECIDE to CLK_OFF when the function-control update is needed, otherwise DECIDE to KICK.
- CLK_OFF to FC_WRITE, FC_WRITE to CLK_ON, CLK_ON to KICK and KICK to WAIT, one cycle each.
- WAIT to IDLE on init completion.

Top module: `phy_speed_cfg_seq`

## Requirements
- R1: After reset the outputs are:
  - busy, slow_bypass, sdio_mode, func_wr, lt_wr, init_start, strobe_en, cmd_ddr and dq_async are 0;
  - dq_ddr is all zeros;
  - card_clk_en is 1.
- R2: When clk_fast is 1 at the accepted apply, slow_bypass becomes 0 whatever the mode and flags.
- R3: In legacy mode (code 0), slow_bypass becomes board_slow. sdio_mode keeps its previous value. No function-control write and no clock gating take place. One init_start pulse follows.
- R4: The mode codes are: 0 legacy, 1 SDR12, 2 SDR25, 3 high-speed, 4 DDR50, 5 DDR52, 6 HS200/SDR104, 7 HS400. With clk_fast at 0, codes 1 to 3 set slow_bypass to card_sdio OR board_slow. Codes 4 to 7 clear slow_bypass.
- R5: When slow_bypass ends up 1, the function-control outputs are left unchanged. No func_wr pulse and no clock gating take place, and the sequencer goes straight to the init_start pulse.
- R6: For every mode other than legacy, sdio_mode takes the value of card_sdio.
- R7: On the fast path:
  - card_clk_en is low for exactly three cycles;
  - func_wr pulses once, in the middle one of those three cycles, so the clock is gated for a full cycle before and after the write;
  - func_wr is never high while card_clk_en is high.
- R8: HS400 (code 7) sets dq_ddr to all ones and cmd_ddr to 1, and clears dq_async.
- R9: DDR50 and DDR52 (codes 4, 5) set dq_ddr to all ones, cmd_ddr to 1 and dq_async to 1. Every other mode that reaches the write clears dq_ddr and cmd_ddr and sets dq_async.
- R10: On the fast path in HS400, lt_wr pulses once with lt_val equal to the LOGIC_TIMING_VALUE parameter, and strobe_en becomes 1. On the fast path in any other mode there is no lt_wr pulse and strobe_en becomes 0.
- R11: Every accepted apply produces exactly one init_start pulse, whichever path it takes.
- R12: busy goes high in the cycle after an accepted apply. It stays high until init_done is seen in the waiting state. An init_done outside that state has no effect.
- R13: The following apply strobes are ignored and leave busy low:
  - an apply whose mode, bus width and clk_fast all equal the last accepted request;
  - an apply that arrives while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| apply | input | 1 | One-cycle request strobe |
| mode_code | input | 3 | Requested speed mode (see R4) |
| card_sdio | input | 1 | Card is SDIO |
| board_slow | input | 1 | Board asks for slow bypass |
| clk_fast | input | 1 | Card clock above 52 MHz |
| bus_width | input | WIDTH_W | Requested bus width code |
| init_done | input | 1 | PHY init sequencer finished |
| busy | output | 1 | Sequence in progress |
| slow_bypass | output | 1 | PHY slow bypass mode |
| sdio_mode | output | 1 | SDIO-mode timing bit |
| card_clk_en | output | 1 | Card clock enable |
| func_wr | output | 1 | Function-control write pulse |
| dq_ddr | output | DQ_LANES | Per data-lane DDR enables |
| cmd_ddr | output | 1 | Command line DDR enable |
| dq_async | output | 1 | Data async mode |
| strobe_en | output | 1 | Data-strobe enable |
| lt_wr | output | 1 | Logic-timing write pulse |
| lt_val | output | LT_W | Logic-timing word |
| init_start | output | 1 | PHY init start pulse |

## Verification
The apply strobe and the completion of a running sequence can land in the same cycle. That is the cycle in which init_done is seen in WAIT and the state returns to IDLE. The bench turns off its automatic init responder and waits for init_start. It then drives init_done and a new apply with a different mode on the same cycle. The new apply must be dropped: busy must fall and stay low, and the function-control outputs must keep the values of the finished request. A second case raises apply in the middle of a running sequence, and the outcome must still follow the first request alone.

// File: rtl/phy_speed_cfg_pkg.sv
package phy_speed_cfg_pkg;

    typedef enum logic [2:0] {
        MODE_LEGACY = 3'd0,
        MODE_SDR12  = 3'd1,
        MODE_SDR25  = 3'd2,
        MODE_HS     = 3'd3,
        MODE_DDR50  = 3'd4,
        MODE_DDR52  = 3'd5,
        MODE_HS200  = 3'd6,
        MODE_HS400  = 3'd7
    } speed_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_CLK_OFF,
        ST_FC_WRITE,
        ST_CLK_ON,
        ST_KICK,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        speed_mode_e mode;
        logic        sdio;
        logic        board_slow;
        logic        fast;
    } cfg_req_t;

endpackage

// File: rtl/phy_mode_decide.sv
module phy_mode_decide
    import phy_speed_cfg_pkg::*;
#(
    parameter int DQ_LANES = 8
) (
    input  cfg_req_t              req,
    output logic                  slow,
    output logic                  hs400,
    output logic [DQ_LANES-1:0]   dq_ddr_n,
    output logic                  cmd_ddr_n,
    output logic                  async_n
);

    localparam logic [DQ_LANES-1:0] ALL_LANES = {DQ_LANES{1'b1}};

    always_comb begin
        slow = 1'b0;
        if (!req.fast) begin
            case (req.mode)
                MODE_LEGACY:                   slow = req.board_slow;
                MODE_SDR12, MODE_SDR25, MODE_HS: slow = req.sdio | req.board_slow;
                default:                       slow = 1'b0;
            endcase
        end
    end

    always_comb begin
        hs400 = (req.mode == MODE_HS400);
        case (req.mode)
            MODE_HS400: begin
                dq_ddr_n  = ALL_LANES;
                cmd_ddr_n = 1'b1;
                async_n   = 1'b0;
            end
            MODE_DDR50, MODE_DDR52: begin
                dq_ddr_n  = ALL_LANES;
                cmd_ddr_n = 1'b1;
                async_n   = 1'b1;
            end
            default: begin
                dq_ddr_n  = '0;
                cmd_ddr_n = 1'b0;
                async_n   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/phy_apply_filter.sv
module phy_apply_filter #(
    parameter int WIDTH_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               apply,
    input  logic               idle,
    input  logic [2:0]         mode_code,
    input  logic [WIDTH_W-1:0] bus_width,
    input  logic               clk_fast,
    output logic               accept
);

    logic               last_valid;
    logic [2:0]         last_mode;
    logic [WIDTH_W-1:0] last_width;
    logic               last_fast;
    logic               same_as_last;

    assign same_as_last = last_valid && (last_mode == mode_code) &&
                          (last_width == bus_width) && (last_fast == clk_fast);
    assign accept = apply && idle && !same_as_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_valid <= 1'b0;
            last_mode  <= '0;
            last_width <= '0;
            last_fast  <= 1'b0;
        end else if (accept) begin
            last_valid <= 1'b1;
            last_mode  <= mode_code;
            last_width <= bus_width;
            last_fast  <= clk_fast;
        end
    end

endmodule

// File: rtl/phy_speed_cfg_seq.sv
module phy_speed_cfg_seq
    import phy_speed_cfg_pkg::*;
#(
    parameter int          DQ_LANES          = 8,
    parameter int          WIDTH_W           = 2,
    parameter int          LT_W              = 32,
    parameter logic [31:0] LOGIC_TIMING_VALUE = 32'h00AA8977
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                apply,
    input  logic [2:0]          mode_code,
    input  logic                card_sdio,
    input  logic                board_slow,
    input  logic                clk_fast,
    input  logic [WIDTH_W-1:0]  bus_width,
    input  logic                init_done,
    output logic                busy,
    output logic                slow_bypass,
    output logic                sdio_mode,
    output logic                card_clk_en,
    output logic                func_wr,
    output logic [DQ_LANES-1:0] dq_ddr,
    output logic                cmd_ddr,
    output logic                dq_async,
    output logic                strobe_en,
    output logic                lt_wr,
    output logic [LT_W-1:0]     lt_val,
    output logic                init_start
);

    seq_state_e          state, state_nx;
    cfg_req_t            req_q;
    logic                accept;
    logic                slow_n, hs400_n, cmd_ddr_n, async_n;
    logic [DQ_LANES-1:0] dq_ddr_n;
    logic                do_fc;

    phy_apply_filter #(.WIDTH_W(WIDTH_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply),
        .idle      (state == ST_IDLE),
        .mode_code (mode_code),
        .bus_width (bus_width),
        .clk_fast  (clk_fast),
        .accept    (accept)
    );

    phy_mode_decide #(.DQ_LANES(DQ_LANES)) u_decide (
        .req       (req_q),
        .slow      (slow_n),
        .hs400     (hs400_n),
        .dq_ddr_n  (dq_ddr_n),
        .cmd_ddr_n (cmd_ddr_n),
        .async_n   (async_n)
    );

    // Legacy mode and slow bypass both skip the function-control update.
    assign do_fc  = !slow_n && (req_q.mode != MODE_LEGACY);
    assign busy   = (state != ST_IDLE);
    assign lt_val = LT_W'(LOGIC_TIMING_VALUE);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept) state_nx = ST_DECIDE;
            ST_DECIDE:   state_nx = do_fc ? ST_CLK_OFF : ST_KICK;
            ST_CLK_OFF:  state_nx = ST_FC_WRITE;
            ST_FC_WRITE: state_nx = ST_CLK_ON;
            ST_CLK_ON:   state_nx = ST_KICK;
            ST_KICK:     state_nx = ST_WAIT;
            ST_WAIT:     if (init_done) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q       <= '0;
            slow_bypass <= 1'b0;
            sdio_mode   <= 1'b0;
            card_clk_en <= 1'b1;
            func_wr     <= 1'b0;
            dq_ddr      <= '0;
            cmd_ddr     <= 1'b0;
            dq_async    <= 1'b0;
            strobe_en   <= 1'b0;
            lt_wr       <= 1'b0;
            init_start  <= 1'b0;
        end else begin
            func_wr    <= 1'b0;
            lt_wr      <= 1'b0;
            init_start <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        req_q.mode       <= speed_mode_e'(mode_code);
                        req_q.sdio       <= card_sdio;
                        req_q.board_slow <= board_slow;
                        req_q.fast       <= clk_fast;
                    end
                end
                ST_DECIDE: begin
                    slow_bypass <= slow_n;
                    if (req_q.mode != MODE_LEGACY) sdio_mode <= req_q.sdio;
                    if (do_fc) card_clk_en <= 1'b0;
                end
                ST_CLK_OFF: begin
                    func_wr  <= 1'b1;
                    dq_ddr   <= dq_ddr_n;
                    cmd_ddr  <= cmd_ddr_n;
                    dq_async <= async_n;
                end
                ST_FC_WRITE: begin
                end
                ST_CLK_ON: begin
                    card_clk_en <= 1'b1;
                    if (hs400_n) begin
                        lt_wr     <= 1'b1;
                        strobe_en <= 1'b1;
                    end else begin
                        strobe_en <= 1'b0;
                    end
                end
                ST_KICK:  init_start <= 1'b1;
                ST_WAIT: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/phy_speed_cfg_chk.sv
module phy_speed_cfg_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic slow_bypass,
    input logic card_clk_en,
    input logic func_wr,
    input logic cmd_ddr,
    input logic dq_async,
    input logic lt_wr,
    input logic init_start,
    input logic init_done
);

    AST_WRITE_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        func_wr |-> !card_clk_en); // R7
    AST_GATE_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk_en) |=> func_wr); // R7
    AST_GATE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        func_wr |=> !card_clk_en); // R7
    AST_NO_WRITE_IN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        func_wr |-> !slow_bypass); // R5
    AST_LT_HS400_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
        lt_wr |-> (card_clk_en && cmd_ddr && !dq_async)); // R10
    AST_INIT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> !init_start); // R11
    AST_INIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> busy); // R11
    AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(init_done)); // R12

endmodule

bind phy_speed_cfg_seq phy_speed_cfg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .slow_bypass (slow_bypass),
    .card_clk_en (card_clk_en),
    .func_wr     (func_wr),
    .cmd_ddr     (cmd_ddr),
    .dq_async    (dq_async),
    .lt_wr       (lt_wr),
    .init_start  (init_start),
    .init_done   (init_done)
);

// File: tb/tb_phy_speed_cfg_seq.sv
module tb_phy_speed_cfg_seq;

    localparam int          DQ = 8;
    localparam int          WW = 2;
    localparam int          LW = 32;
    localparam logic [31:0] LTV = 32'h00AA8977;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          apply = 1'b0;
    logic [2:0]    mode_code = '0;
    logic          card_sdio = 1'b0, board_slow = 1'b0, clk_fast = 1'b0;
    logic [WW-1:0] bus_width = '0;
    logic          resp_done = 1'b0, man_done = 1'b0, auto_done = 1'b1;
    logic          init_done;
    logic          busy, slow_bypass, sdio_mode, card_clk_en, func_wr;
    logic [DQ-1:0] dq_ddr;
    logic          cmd_ddr, dq_async, strobe_en, lt_wr, init_start;
    logic [LW-1:0] lt_val;

    int n_chk = 0, n_fail = 0;
    int c_fw, c_fw_bad, c_off, c_init, c_lt, c_lt_bad;
    bit took, finished = 0;

    assign init_done = resp_done | man_done;

    always #5 clk = ~clk;

    phy_speed_cfg_seq #(.DQ_LANES(DQ), .WIDTH_W(WW), .LT_W(LW),
                        .LOGIC_TIMING_VALUE(LTV)) dut (
        .clk(clk), .rst_n(rst_n), .apply(apply), .mode_code(mode_code),
        .card_sdio(card_sdio), .board_slow(board_slow), .clk_fast(clk_fast),
        .bus_width(bus_width), .init_done(init_done), .busy(busy),
        .slow_bypass(slow_bypass), .sdio_mode(sdio_mode),
        .card_clk_en(card_clk_en), .func_wr(func_wr), .dq_ddr(dq_ddr),
        .cmd_ddr(cmd_ddr), .dq_async(dq_async), .strobe_en(strobe_en),
        .lt_wr(lt_wr), .lt_val(lt_val), .init_start(init_start)
    );

    // Init sequencer model: completes two cycles after the start pulse.
    initial begin
        forever begin
            @(negedge clk);
            resp_done = 1'b0;
            if (auto_done && init_start) begin
                repeat (2) @(negedge clk);
                resp_done = 1'b1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] m, input logic sd, input logic bs,
                       input logic fst, input logic [WW-1:0] w);
        @(negedge clk);
        mode_code = m; card_sdio = sd; board_slow = bs; clk_fast = fst; bus_width = w;
        apply = 1'b1;
        @(negedge clk);
        apply = 1'b0;
        took = busy;
        c_fw = 0; c_fw_bad = 0; c_off = 0; c_init = 0; c_lt = 0; c_lt_bad = 0;
        for (int i = 0; i < 200 && busy; i++) begin
            if (func_wr) c_fw++;
            if (func_wr && card_clk_en) c_fw_bad++;
            if (!card_clk_en) c_off++;
            if (init_start) c_init++;
            if (lt_wr) c_lt++;
            if (lt_wr && lt_val != LTV) c_lt_bad++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 slow", slow_bypass, 0);
        check("R1 sdio", sdio_mode, 0);
        check("R1 clk_en", card_clk_en, 1);
        check("R1 ddr", {dq_ddr, cmd_ddr, dq_async, strobe_en}, 0);
        check("R1 pulses", {func_wr, lt_wr, init_start}, 0);
    endtask

    task automatic t_legacy_slow();
        run(3'd0, 1'b1, 1'b1, 1'b0, 2'd0);
        check("R12 busy rose", took, 1);
        check("R3 slow follows board", slow_bypass, 1);
        check("R3 sdio kept", sdio_mode, 0);
        check("R3 no write", c_fw, 0);
        check("R3 no gating", c_off, 0);
        check("R11 init once", c_init, 1);
    endtask

    task automatic t_hs400();
        run(3'd7, 1'b0, 1'b1, 1'b1, 2'd2);
        check("R2 fast clears slow", slow_bypass, 0);
        check("R8 ddr", {dq_ddr, cmd_ddr, dq_async}, {8'hFF, 1'b1, 1'b0});
        check("R10 lt pulse", c_lt, 1);
        check("R10 lt value", c_lt_bad, 0);
        check("R10 strobe set", strobe_en, 1);
        check("R7 gated cycles", c_off, 3);
        check("R7 one write", c_fw, 1);
        check("R7 write under gate", c_fw_bad, 0);
        check("R7 clock back", card_clk_en, 1);
        check("R11 init once", c_init, 1);
    endtask

    task automatic t_ddr52_and_repeat();
        run(3'd5, 1'b0, 1'b0, 1'b1, 2'd2);
        check("R9 ddr52", {dq_ddr, cmd_ddr, dq_async}, {8'hFF, 1'b1, 1'b1});
        check("R10 strobe cleared", strobe_en, 0);
        check("R10 no lt", c_lt, 0);
        run(3'd5, 1'b1, 1'b1, 1'b1, 2'd2);
        check("R13 repeat ignored", took, 0);
        check("R13 no init", c_init, 0);
        check("R13 sdio untouched", sdio_mode, 0);
    endtask

    task automatic t_sdr25_sdio();
        run(3'd2, 1'b1, 1'b0, 1'b0, 2'd1);
        check("R4 sdio gives slow", slow_bypass, 1);
        check("R6 sdio mode set", sdio_mode, 1);
        check("R5 no write", c_fw, 0);
        check("R5 no gating", c_off, 0);
        check("R5 settings kept", {dq_ddr, cmd_ddr, dq_async}, {8'hFF, 1'b1, 1'b1});
        check("R11 init once", c_init, 1);
    endtask

    task automatic t_hs_plain();
        run(3'd3, 1'b0, 1'b0, 1'b0, 2'd1);
        check("R4 hs no slow", slow_bypass, 0);
        check("R6 sdio cleared", sdio_mode, 0);
        check("R9 sdr settings", {dq_ddr, cmd_ddr, dq_async}, {8'h00, 1'b0, 1'b1});
        check("R7 one write", c_fw, 1);
    endtask

    task automatic t_hs200_flags();
        run(3'd6, 1'b1, 1'b1, 1'b1, 2'd2);
        check("R4 hs200 no slow", slow_bypass, 0);
        check("R6 sdio set", sdio_mode, 1);
        check("R9 hs200 settings", {dq_ddr, cmd_ddr, dq_async}, {8'h00, 1'b0, 1'b1});
    endtask

    task automatic t_legacy_fast_path_skip();
        run(3'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        check("R3 slow off", slow_bypass, 0);
        check("R3 sdio kept", sdio_mode, 1);
        check("R3 no write", c_fw, 0);
        check("R11 init once", c_init, 1);
        run(3'd1, 1'b0, 1'b1, 1'b1, 2'd0);
        check("R2 sdr12 fast", slow_bypass, 0);
        check("R7 one write", c_fw, 1);
    endtask

    task automatic t_stray_done();
        @(negedge clk); man_done = 1'b1;
        @(negedge clk); man_done = 1'b0;
        check("R12 stray done", busy, 0);
    endtask

    task automatic t_apply_while_busy();
        @(negedge clk);
        mode_code = 3'd7; card_sdio = 0; board_slow = 0; clk_fast = 1; bus_width = 2'd3;
        apply = 1'b1;
        @(negedge clk); apply = 1'b0;
        @(negedge clk); mode_code = 3'd4; apply = 1'b1;
        @(negedge clk); apply = 1'b0;
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R13 busy apply ignored", busy, 0);
        check("R13 first request wins", dq_async, 0);
    endtask

    task automatic t_done_collides_apply();
        auto_done = 1'b0;
        run_start(3'd4);
        for (int i = 0; i < 50 && !init_start; i++) @(negedge clk);
        @(negedge clk);
        man_done = 1'b1; mode_code = 3'd3; apply = 1'b1;
        @(negedge clk);
        man_done = 1'b0; apply = 1'b0;
        check("R12 busy falls on done", busy, 0);
        repeat (3) @(negedge clk);
        check("R13 collide apply dropped", busy, 0);
        check("R9 ddr50 kept", {dq_ddr, cmd_ddr, dq_async}, {8'hFF, 1'b1, 1'b1});
        auto_done = 1'b1;
    endtask

    task automatic run_start(input logic [2:0] m);
        @(negedge clk);
        mode_code = m; card_sdio = 0; board_slow = 0; clk_fast = 1; bus_width = 2'd0;
        apply = 1'b1;
        @(negedge clk); apply = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legacy_slow();
        t_hs400();
        t_ddr52_and_repeat();
        t_sdr25_sdio();
        t_hs_plain();
        t_hs200_flags();
        t_legacy_fast_path_skip();
        t_stray_done();
        t_apply_while_busy();
        t_done_collides_apply();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule